// File: doc/BRIEF.md
# Two-Road Crossing Light Sequencer

This block controls the lights at a crossing where two roads meet, called road A and road B. Each road has one vehicle sensor input. The sensor is high while traffic is present in either direction of travel on that road. The block drives a 2-bit light command for each road. A road keeps its green for as long as its own sensor reports traffic. When the sensor goes quiet, that road gets one yellow step, and then the right of way passes to the other road.

The machine is a Moore machine with four phases. The light commands are decoded from the current phase alone. The block runs from the fast system clock. A built-in prescaler produces a one-cycle step pulse every `CLK_HZ * STEP_SEC` clocks, which is 5 seconds by default. The phase register may change only on that pulse. Between pulses the sensors have no visible effect. Reset puts the crossing at road A green and road B red, and restarts the prescaler.

Top module: `tlc_crossing`

## Requirements
- R1: Light command encoding is green = 2'b00, yellow = 2'b01, red = 2'b10. The four phases drive these commands (road A, road B):
  - A-go: green, red.
  - A-warn: yellow, red.
  - B-go: red, green.
  - B-warn: red, yellow.
- R2: While `rst_ni` is low, the outputs show road A green and road B red, and the prescaler is cleared. The first phase change after release can occur no earlier than the `STEP_CYCLES`-th rising clock edge after release.
- R3: The phase, and so both light commands, changes only on the clock edge where the step pulse is high. Sensor activity between step pulses does not alter either output.
- R4: At a step in A-go, the machine stays in A-go if `road_a_busy_i` is 1, and moves to A-warn if it is 0.
- R5: At a step in A-warn, the machine moves to B-go, whatever the sensor values are.
- R6: At a step in B-go, the machine stays in B-go if `road_b_busy_i` is 1, and moves to B-warn if it is 0.
- R7: At a step in B-warn, the machine moves to A-go, whatever the sensor values are.
- R8: The two roads never show a non-red command at the same time. Whenever one road is not red, the other is red (2'b10).
- R9: The step pulse is high for exactly one clock. It repeats every `STEP_CYCLES = CLK_HZ * STEP_SEC` clocks, and the prescaler count returns to zero after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| road_a_busy_i | input | 1 | Road A sensor: traffic present in either direction |
| road_b_busy_i | input | 1 | Road B sensor: traffic present in either direction |
| light_a_o | output | 2 | Light command for road A (00 green, 01 yellow, 10 red) |
| light_b_o | output | 2 | Light command for road B (00 green, 01 yellow, 10 red) |

## Verification
The assertions check, on every cycle:
- the phase stays put unless the step pulse is high;
- each phase makes its correct transition at a step, for both sensor values;
- the step pulse lasts one cycle and restarts the count;
- the two roads are never both non-red.

Only the bench's scenarios can show the rest. These are the exact command values for each phase, and the fact that the first step lands a full period after reset is released. They also include the claim that sensor activity in the middle of a period leaves the lights alone, since the bench watches the ports at the cycle just before and just after each step edge.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    LIGHT_GREEN  = 2'b00,
    LIGHT_YELLOW = 2'b01,
    LIGHT_RED    = 2'b10
  } light_e;

  typedef enum logic [1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phase_e;
endpackage

// File: rtl/tlc_step_gen.sv
module tlc_step_gen #(
  parameter longint unsigned STEP_CYCLES = 1_000_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int CNT_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign step_o = (cnt_q == LAST);

  initial assert (STEP_CYCLES >= 2) else $error("STEP_CYCLES must be at least 2");

  assert_step_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
  assert_step_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == '0));
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  input  logic   road_a_busy_i,
  input  logic   road_b_busy_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_A_GO:   phase_d = road_a_busy_i ? PH_A_GO : PH_A_WARN;
      PH_A_WARN: phase_d = PH_B_GO;
      PH_B_GO:   phase_d = road_b_busy_i ? PH_B_GO : PH_B_WARN;
      PH_B_WARN: phase_d = PH_A_GO;
      default:   phase_d = PH_A_GO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= PH_A_GO;
    else if (step_i) phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_hold_between_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));
  assert_a_stay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_A_GO && road_a_busy_i) |=> (phase_q == PH_A_GO));
  assert_a_leave_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_A_GO && !road_a_busy_i) |=> (phase_q == PH_A_WARN));
  assert_a_warn_to_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_A_WARN) |=> (phase_q == PH_B_GO));
  assert_b_stay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_B_GO && road_b_busy_i) |=> (phase_q == PH_B_GO));
  assert_b_leave_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_B_GO && !road_b_busy_i) |=> (phase_q == PH_B_WARN));
  assert_b_warn_to_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_B_WARN) |=> (phase_q == PH_A_GO));
endmodule

// File: rtl/tlc_light_decode.sv
module tlc_light_decode
  import tlc_pkg::*;
(
  input  phase_e phase_i,
  output light_e light_a_o,
  output light_e light_b_o
);
  always_comb begin
    unique case (phase_i)
      PH_A_GO:   begin light_a_o = LIGHT_GREEN;  light_b_o = LIGHT_RED;    end
      PH_A_WARN: begin light_a_o = LIGHT_YELLOW; light_b_o = LIGHT_RED;    end
      PH_B_GO:   begin light_a_o = LIGHT_RED;    light_b_o = LIGHT_GREEN;  end
      PH_B_WARN: begin light_a_o = LIGHT_RED;    light_b_o = LIGHT_YELLOW; end
      default:   begin light_a_o = LIGHT_RED;    light_b_o = LIGHT_RED;    end
    endcase
  end
endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
  import tlc_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned STEP_SEC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       road_a_busy_i,
  input  logic       road_b_busy_i,
  output logic [1:0] light_a_o,
  output logic [1:0] light_b_o
);
  localparam longint unsigned STEP_CYCLES = longint'(CLK_HZ) * longint'(STEP_SEC);

  logic   step;
  phase_e phase;
  light_e light_a, light_b;

  tlc_step_gen #(.STEP_CYCLES(STEP_CYCLES)) u_step_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (step)
  );

  tlc_phase_fsm u_phase_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (step),
    .road_a_busy_i (road_a_busy_i),
    .road_b_busy_i (road_b_busy_i),
    .phase_o       (phase)
  );

  tlc_light_decode u_light_decode (
    .phase_i   (phase),
    .light_a_o (light_a),
    .light_b_o (light_b)
  );

  assign light_a_o = light_a;
  assign light_b_o = light_b;

  assert_never_both_go_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (light_a_o != LIGHT_RED) |-> (light_b_o == LIGHT_RED));
  assert_lights_follow_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> ($stable(light_a_o) && $stable(light_b_o)));
endmodule

// File: tb/tlc_crossing_bench.sv
module tlc_crossing_bench;
  localparam int N = 4;  // CLK_HZ=4, STEP_SEC=1

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       road_a_busy_i = 1'b0;
  logic       road_b_busy_i = 1'b0;
  logic [1:0] light_a_o, light_b_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] cur_a, cur_b;

  localparam logic [1:0] GRN = 2'b00, YEL = 2'b01, RED = 2'b10;

  tlc_crossing #(.CLK_HZ(4), .STEP_SEC(1)) u_tlc_crossing (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .road_a_busy_i (road_a_busy_i),
    .road_b_busy_i (road_b_busy_i),
    .light_a_o     (light_a_o),
    .light_b_o     (light_b_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check_lights(input logic [1:0] ea, input logic [1:0] eb, input string tag);
    checks++;
    if (light_a_o !== ea || light_b_o !== eb) begin
      errors++;
      $display("FAIL %s: got A=%b B=%b expected A=%b B=%b", tag, light_a_o, light_b_o, ea, eb);
    end
    checks++;
    if (light_a_o !== RED && light_b_o !== RED) begin
      errors++;
      $display("FAIL R8: got A=%b B=%b expected at least one red", light_a_o, light_b_o);
    end
    cur_a = ea;
    cur_b = eb;
  endtask

  // Starts at a negedge at phase 0 of a step period. Toggles sensors mid-period,
  // sets the final values before the step edge, checks before and after it.
  task automatic do_step(input logic a, input logic b,
                         input logic [1:0] ea, input logic [1:0] eb, input string tag);
    logic [1:0] pa, pb;
    pa = cur_a;
    pb = cur_b;
    for (int i = 0; i < N - 2; i++) begin
      road_a_busy_i = ~a;
      road_b_busy_i = ~b;
      @(negedge clk_i);
    end
    road_a_busy_i = a;
    road_b_busy_i = b;
    @(negedge clk_i);
    check_lights(pa, pb, "R3 before step edge");
    @(negedge clk_i);
    check_lights(ea, eb, tag);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_lights(GRN, RED, "R2 during reset");
    rst_ni = 1'b1;
  endtask

  task automatic test_a_side();
    do_step(1'b1, 1'b0, GRN, RED, "R4 A stays green while busy");
    do_step(1'b1, 1'b1, GRN, RED, "R4 A stays green with both busy");
    do_step(1'b0, 1'b1, YEL, RED, "R4 A goes yellow when idle; R1 A-warn code");
    do_step(1'b1, 1'b0, RED, GRN, "R5 A-warn to B-go ignoring sensors; R1 B-go code");
  endtask

  task automatic test_b_side();
    do_step(1'b0, 1'b1, RED, GRN, "R6 B stays green while busy");
    do_step(1'b1, 1'b1, RED, GRN, "R6 B stays green with both busy");
    do_step(1'b1, 1'b0, RED, YEL, "R6 B goes yellow when idle; R1 B-warn code");
    do_step(1'b0, 1'b1, GRN, RED, "R7 B-warn to A-go ignoring sensors; R1 A-go code");
  endtask

  task automatic test_quiet_cycle();
    do_step(1'b0, 1'b0, YEL, RED, "R4 idle A leaves green");
    do_step(1'b0, 1'b0, RED, GRN, "R5 with no traffic");
    do_step(1'b0, 1'b0, RED, YEL, "R6 idle B leaves green");
    do_step(1'b0, 1'b0, GRN, RED, "R7 with no traffic");
  endtask

  task automatic test_mid_reset();
    do_step(1'b0, 1'b0, YEL, RED, "R4 before mid reset");
    do_step(1'b0, 1'b0, RED, GRN, "R5 before mid reset");
    road_a_busy_i = 1'b0;
    road_b_busy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_lights(GRN, RED, "R2 async reset returns to A green");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // First step must land exactly N edges after release (R2, R9)
    do_step(1'b0, 1'b0, YEL, RED, "R2 first step one full period after release");
    do_step(1'b0, 1'b0, RED, GRN, "R9 next step one period later");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    cur_a = GRN;
    cur_b = RED;
    @(negedge clk_i);
    test_reset();
    test_a_side();
    test_b_side();
    test_quiet_cycle();
    test_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule